// File: doc/BRIEF.md
# SPI Register-Write Framer with Data/Command Select

This block turns register-write requests from an on-chip controller into transfers on a four-wire SPI link to a small TFT panel controller. A request carries an 8-bit register index and one of two payloads. The first is a single 16-bit register value. The second is a pixel burst whose length is given in bytes and whose data arrives on a valid/ready word stream. The block drives the serial clock, the serial data line, an active-low chip select and a data/command select line. It reports `busy` and a one-cycle `done` to the requester.

The index byte always goes out first, with the select line low. The select line goes high before any payload bit. A register value is sent high byte first. Pixel bursts are framed in one of two ways, depending on the target index and on whether the requester asked for byte swapping. For a frame update the caller computes the byte count as width × height × 2.

Top module: `spi_regwr_framer`

## Requirements
- R1: Reset state: `cs_n`=1, `sclk`=0, `dc`=0, `busy`=0, `done`=0 and `pix_ready`=0.
- R2: SPI mode 0. `sclk` idles low. `mosi` changes only while `sclk` is low, and it is stable across every `sclk` high phase. Each byte or word is sent MSB first.
- R3: Every transaction starts with the 8 bits of `req_index`, and `dc` is 0 at each of those 8 rising `sclk` edges.
- R4: `dc` is 1 at every rising `sclk` edge that carries a payload bit. `dc` changes only while `sclk` is low.
- R5: When `req_burst`=0, the index is followed by exactly 16 bits of `req_value`: high byte first, then low byte. The transaction has 24 `sclk` pulses in total.
- R6: A burst request with `req_len`=0 ends after the 8 index bits. No `pix_ready` cycle occurs and `dc` stays 0.
- R7: Word framing applies when the index equals `GRAM_INDEX` (default 8'h22) and `req_swap`=0. Each stream word is sent as 16 bits, MSB first (bits 15..0). ceil(`req_len`/2) words are taken, so an odd length still sends the whole last word.
- R8: All other bursts use byte framing. Each stream word is sent as its low byte (bits 7..0) followed by its high byte (bits 15..8). The burst sends exactly 8×`req_len` bits. For an odd length only the low byte of the last word is sent.
- R9: Each `sclk` high phase and each low phase inside a unit lasts `SCLK_HALF` system clocks, so the divider is 2×`SCLK_HALF` ≥ 2.
- R10: `cs_n` falls once per request, in the cycle after acceptance. It stays low through the last bit, and then rises `SCLK_HALF` cycles after the final falling `sclk` edge, with `sclk` low.
- R11: `done` is high for exactly one cycle, in the cycle where `cs_n` has just risen. `busy` is high from the cycle after acceptance until then. A `req_valid` seen while `busy` is high is ignored.
- R12: `pix_ready` is high only while the block waits for the next stream word. During such a stall `sclk` holds low, and the serial output resumes intact when `pix_valid` returns.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_index | input | 8 | Register index sent first |
| req_value | input | 16 | Register value for non-burst requests |
| req_burst | input | 1 | 1 = pixel burst, 0 = register write |
| req_len | input | LEN_W | Burst length in bytes |
| req_swap | input | 1 | Byte swapping requested (selects byte framing) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| pix_data | input | 16 | Pixel stream word |
| pix_valid | input | 1 | Pixel stream word valid |
| pix_ready | output | 1 | Block takes a stream word this cycle |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI serial data out |
| cs_n | output | 1 | SPI chip select, active low |
| dc | output | 1 | Data/command select: 0 index, 1 payload |

## Verification
The hardest situation to reach from the ports is an odd-length burst that is stalled by the pixel stream in the middle, in each of the two framing modes. In that case the last word is treated differently, and the serial clock must be held low while data is missing. The stimulus sweeps lengths 0 to 5 over both a graphics-RAM index and a plain index, with swapping off and on. The stream source withholds `pix_valid` on a fixed fraction of cycles. Every captured bit and select level is compared against a stream rebuilt arithmetically from the same word generator.

// File: rtl/spi_regwr_framer.sv
module spi_regwr_framer #(
  parameter int          SCLK_HALF  = 2,
  parameter int          LEN_W      = 12,
  parameter logic [7:0]  GRAM_INDEX = 8'h22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [7:0]       req_index,
  input  logic [15:0]      req_value,
  input  logic             req_burst,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_swap,
  output logic             busy,
  output logic             done,
  input  logic [15:0]      pix_data,
  input  logic             pix_valid,
  output logic             pix_ready,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  output logic             dc
);
  localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_HALF - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_FETCH, S_TAIL} state_t;

  state_t           state;
  logic [15:0]      sh, val_q;
  logic [4:0]       bitcnt;
  logic [DIV_W-1:0] div;
  logic [LEN_W-1:0] rem;
  logic             sclk_q, cs_q, dc_q, done_q;
  logic             in_index, is_burst, word_q;

  wire tick = (div == DIV_LAST);

  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign pix_ready = (state == S_FETCH);
  assign sclk      = sclk_q;
  assign mosi      = sh[15];
  assign cs_n      = cs_q;
  assign dc        = dc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sh       <= '0;
      val_q    <= '0;
      bitcnt   <= '0;
      div      <= '0;
      rem      <= '0;
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      dc_q     <= 1'b0;
      done_q   <= 1'b0;
      in_index <= 1'b0;
      is_burst <= 1'b0;
      word_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            state    <= S_SHIFT;
            cs_q     <= 1'b0;
            dc_q     <= 1'b0;
            sh       <= {req_index, 8'h00};
            bitcnt   <= 5'd8;
            div      <= '0;
            sclk_q   <= 1'b0;
            in_index <= 1'b1;
            is_burst <= req_burst;
            rem      <= req_burst ? req_len : '0;
            word_q   <= (req_index == GRAM_INDEX) && !req_swap;
            val_q    <= req_value;
          end
        end
        S_SHIFT: begin
          if (!tick) begin
            div <= div + 1'b1;
          end else begin
            div <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              sh     <= {sh[14:0], 1'b0};
              bitcnt <= bitcnt - 1'b1;
              if (bitcnt == 5'd1) begin
                in_index <= 1'b0;
                if (in_index && !is_burst) begin
                  sh     <= val_q;
                  bitcnt <= 5'd16;
                  dc_q   <= 1'b1;
                end else if (rem != '0) begin
                  state <= S_FETCH;
                  dc_q  <= 1'b1;
                end else begin
                  state <= S_TAIL;
                end
              end
            end
          end
        end
        S_FETCH: begin
          if (pix_valid) begin
            state <= S_SHIFT;
            div   <= '0;
            sh    <= word_q ? pix_data : {pix_data[7:0], pix_data[15:8]};
            if (!word_q && rem == LEN_W'(1)) begin
              bitcnt <= 5'd8;
              rem    <= '0;
            end else begin
              bitcnt <= 5'd16;
              rem    <= (rem >= LEN_W'(2)) ? rem - LEN_W'(2) : '0;
            end
          end
        end
        S_TAIL: begin
          if (!tick) begin
            div <= div + 1'b1;
          end else begin
            div    <= '0;
            cs_q   <= 1'b1;
            dc_q   <= 1'b0;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module spi_regwr_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic pix_ready,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic dc
);
  a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  a_r4_dc_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dc) |-> !sclk);
  a_r10_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_done_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));
  a_r11_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  a_r12_stall_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (!sclk && !cs_n && dc));
endmodule

bind spi_regwr_framer spi_regwr_framer_chk chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pix_ready(pix_ready),
  .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .dc(dc)
);

// File: tb/spi_regwr_framer_test.sv
`timescale 1ns/1ps
module spi_regwr_framer_test;
  localparam int HALF = 2;
  localparam int LW   = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_burst = 0, req_swap = 0, pix_valid = 0;
  logic [7:0] req_index = 0;
  logic [15:0] req_value = 0, pix_data = 0;
  logic [LW-1:0] req_len = 0;
  logic busy, done, pix_ready, sclk, mosi, cs_n, dc;

  spi_regwr_framer #(.SCLK_HALF(HALF), .LEN_W(LW), .GRAM_INDEX(8'h22)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
    .req_value(req_value), .req_burst(req_burst), .req_len(req_len),
    .req_swap(req_swap), .busy(busy), .done(done), .pix_data(pix_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .dc(dc));

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] gen_word(input int k);
    return (16'(k) * 16'h9E37) ^ 16'h5AC3;
  endfunction

  logic cap_bit [0:255];
  logic cap_dc  [0:255];
  logic exp_bit [0:255];
  logic exp_dc  [0:255];
  int cap_n = 0, exp_n = 0;
  int cs_falls = 0, done_cnt = 0, hs_cnt = 0;
  int hi_err = 0, mosi_err = 0, done_wide = 0, done_cs_err = 0;
  realtime t_rise = 0;

  always @(posedge sclk) begin
    if (cap_n < 256) begin
      cap_bit[cap_n] = mosi;
      cap_dc[cap_n]  = dc;
    end
    cap_n++;
    t_rise = $realtime;
  end
  always @(negedge sclk) if (($realtime - t_rise) != HALF * 10.0) hi_err++;

  int feed_k = 0, cyc = 0;
  bit hs_pend = 0, stall_en = 0, prev_sclk = 0, prev_mosi = 0, prev_done = 0, prev_cs = 1;
  always @(negedge clk) begin
    cyc++;
    if (hs_pend) begin feed_k++; hs_cnt++; end
    pix_valid = stall_en ? ((cyc % 3) != 0) : 1'b1;
    pix_data  = gen_word(feed_k);
    hs_pend   = pix_valid && pix_ready;
    if (prev_sclk && sclk && (mosi != prev_mosi)) mosi_err++;
    if (prev_cs && !cs_n) cs_falls++;
    if (done) begin
      done_cnt++;
      if (prev_done) done_wide++;
      if (!cs_n) done_cs_err++;
    end
    prev_sclk = sclk; prev_mosi = mosi; prev_done = done; prev_cs = cs_n;
  end

  task automatic push(input logic [15:0] v, input int n, input logic d);
    for (int i = n - 1; i >= 0; i--) begin
      exp_bit[exp_n] = v[i];
      exp_dc[exp_n]  = d;
      exp_n++;
    end
  endtask

  task automatic run_req(input logic [7:0] idx, input logic [15:0] val, input bit burst,
                         input int len, input bit swap, input bit stall, input bit poke,
                         input string tag);
    int words, timeout, ierr, perr, derr;
    bit wmode;
    exp_n = 0;
    wmode = (idx == 8'h22) && !swap;
    words = burst ? (len + 1) / 2 : 0;
    push({8'h00, idx}, 8, 1'b0);
    if (!burst) push(val, 16, 1'b1);
    for (int w = 0; w < words; w++) begin
      logic [15:0] d;
      d = gen_word(w);
      if (wmode) push(d, 16, 1'b1);
      else if ((len % 2 == 1) && (w == words - 1)) push({8'h00, d[7:0]}, 8, 1'b1);
      else push({d[7:0], d[15:8]}, 16, 1'b1);
    end
    @(negedge clk);
    cap_n = 0; cs_falls = 0; done_cnt = 0; hs_cnt = 0; feed_k = 0; hs_pend = 0;
    stall_en = stall;
    req_index = idx; req_value = val; req_burst = burst; req_len = LW'(len);
    req_swap = swap; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(busy == 1, "R11 busy after accept", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_index = 8'hFF; req_burst = 0; req_value = 16'hFFFF; req_valid = 1;
      repeat (4) @(negedge clk);
      req_valid = 0;
    end
    timeout = 0;
    while (done_cnt == 0 && timeout < 5000) begin @(negedge clk); timeout++; end
    check(timeout < 5000, {tag, " watchdog"}, timeout, 0);
    repeat (3) @(negedge clk);
    check(cap_n == exp_n, {tag, " bit count"}, cap_n, exp_n);
    ierr = 0; perr = 0; derr = 0;
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      if (cap_bit[i] !== exp_bit[i]) begin if (i < 8) ierr++; else perr++; end
      if (cap_dc[i] !== exp_dc[i]) derr++;
    end
    check(ierr == 0, "R3 index bits", ierr, 0);
    check(perr == 0, {tag, " payload bits"}, perr, 0);
    check(derr == 0, "R4 dc levels", derr, 0);
    check(cs_falls == 1, "R10 one CS window", cs_falls, 1);
    check(done_cnt == 1, "R11 one done", done_cnt, 1);
    check(hs_cnt == words, "R12 stream words taken", hs_cnt, words);
    check(busy == 0 && cs_n == 1 && sclk == 0, "R10 idle after", {busy, cs_n, sclk}, 3'b010);
  endtask

  initial begin
    #2ms;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1 && sclk == 0 && dc == 0 && busy == 0 && done == 0 && pix_ready == 0,
          "R1 reset state", {cs_n, sclk, dc, busy, done, pix_ready}, 6'b100000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_req(8'h10, 16'h0800, 0, 0, 0, 0, 0, "R5 reg write");
    run_req(8'h03, 16'h1030, 0, 0, 0, 0, 0, "R5 reg write");
    run_req(8'h22, 16'hBEEF, 0, 0, 0, 0, 0, "R5 reg write gram idx");
    run_req(8'hA5, 16'h8001, 0, 0, 0, 0, 1, "R11 ignored while busy");
    for (int sw = 0; sw < 2; sw++)
      for (int ix = 0; ix < 2; ix++)
        for (int ln = 0; ln < 6; ln++)
          for (int st = 0; st < 2; st++) begin
            logic [7:0] idx;
            string tg;
            idx = (ix == 0) ? 8'h22 : 8'h36;
            if (ln == 0) tg = "R6 empty burst";
            else if (idx == 8'h22 && sw == 0) tg = "R7 word burst";
            else tg = "R8 byte burst";
            run_req(idx, 16'h0000, 1, ln, sw[0], st[0], 0, tg);
          end
    run_req(8'h22, 16'h0000, 1, 8, 0, 1, 0, "R7 word burst 2x2 frame");
    run_req(8'h22, 16'h0000, 1, 6, 1, 1, 0, "R8 byte burst 1x3 frame");

    check(mosi_err == 0, "R2 mosi stable while sclk high", mosi_err, 0);
    check(hi_err == 0, "R9 sclk high phase", hi_err, 0);
    check(done_wide == 0, "R11 done one cycle", done_wide, 0);
    check(done_cs_err == 0, "R11 done with cs high", done_cs_err, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule